// File: doc/BRIEF.md
# Bit Group Partition Unit

The unit splits a data word into two groups under a control word of the same width and packs them side by side. Data bits whose control bit is 0 are packed toward the left end of the result. Data bits whose control bit is 1 are packed toward the right end. Each group keeps the relative order its bits had in the input. Position 0 is the left end and maps to the most significant bit of each bus.

The core is combinational. A tree of merge stages collects the zero-control bits. At each merge the one-hot count of padded zeros in the left half sets how far the right half shifts in. A second copy of the same tree collects the one-control bits: it gets the inverted control bits, with data and control fed in reverse order. The two partial words do not overlap, so an OR joins them. A parameter can add an output register that loads on a valid strobe. With the register the result appears one cycle after it is requested and holds until the next request.

Top module: `bit_partition`

## Requirements
- R1: Every data bit whose control bit is 0 appears in the leftmost positions of `dataOut`, in the same relative order as in `dataIn`. Position 0 is bit WIDTH-1.
- R2: Every data bit whose control bit is 1 appears in the rightmost positions of `dataOut`, in the same relative order as in `dataIn`.
- R3: The result is a permutation of the input. It has the same number of set bits, and no output position is claimed by both groups.
- R4: With an all-zero control word, `dataOut` equals `dataIn`.
- R5: With an all-ones control word, `dataOut` equals `dataIn`.
- R6: With control 0x5555…5 (position 0 has control 0), the output holds the even-position bits followed by the odd-position bits.
- R7: At WIDTH 8, data 8'b10110011 with control 8'b10011010 gives 8'b01011101.
- R8: With the output register enabled (OUT_REG=1), a word presented with `inValid` high appears on `dataOut` after the next rising edge. `outValid` is high for exactly that cycle, and `dataOut` holds its value while `inValid` stays low.
- R9: While `rstN` is low, `dataOut` is all zeros and `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Loads a new result when high |
| dataIn | input | WIDTH | Data word to partition |
| ctrlIn | input | WIDTH | Group select for each data bit |
| outValid | output | 1 | Marks the cycle a new result is present |
| dataOut | output | WIDTH | Partitioned word |

## Verification
A wrong one-hot padded-zero count at any merge level shifts a whole run of right-half bits by one or more places. A single pattern then shows both duplicated and lost bits in the same cycle that the result register loads, and the permutation property breaks at once. A merge fault that only some alignments reach stays hidden until a control word with that exact left-half fill comes in. The bench therefore sweeps random control words on top of the uniform and alternating ones. The register path is checked by comparing the word held over idle cycles with the word it loaded.

// File: rtl/bitpart_pkg.sv
package bitpart_pkg;
  typedef struct packed {
    logic load;
  } strobe_t;
endpackage

// File: rtl/bitpart_merge.sv
module bitpart_merge #(
  parameter int HALF = 1
) (
  input  logic [HALF-1:0]   lData,
  input  logic [HALF:0]     lCnt,
  input  logic [HALF-1:0]   rData,
  input  logic [HALF:0]     rCnt,
  output logic [2*HALF-1:0] mData,
  output logic [2*HALF:0]   mCnt
);
  // index = position within the group, 0 = left end
  always_comb begin
    mData = '0;
    mData[HALF-1:0] = lData;
    for (int k = 0; k <= HALF; k++) begin
      for (int j = 0; j < HALF; j++) begin
        mData[HALF-k+j] = mData[HALF-k+j] | (lCnt[k] & rData[j]);
      end
    end
  end

  always_comb begin
    mCnt = '0;
    for (int a = 0; a <= HALF; a++) begin
      for (int b = 0; b <= HALF; b++) begin
        mCnt[a+b] = mCnt[a+b] | (lCnt[a] & rCnt[b]);
      end
    end
  end
endmodule

// File: rtl/bitpart_gather.sv
module bitpart_gather #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] dPos,
  input  logic [WIDTH-1:0] cPos,
  output logic [WIDTH-1:0] gPos,
  output logic [WIDTH:0]   padCnt
);
  localparam int LEVELS = $clog2(WIDTH);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int SZ = 1 << l;
    localparam int NG = WIDTH >> l;
    logic [SZ-1:0] dat [NG];
    logic [SZ:0]   cnt [NG];
    if (l == 0) begin : g_leaf
      for (genvar g = 0; g < NG; g++) begin : g_cell
        assign dat[g] = cPos[g] ? 1'b0 : dPos[g];
        assign cnt[g] = cPos[g] ? 2'b10 : 2'b01;
      end
    end else begin : g_join
      for (genvar g = 0; g < NG; g++) begin : g_cell
        bitpart_merge #(.HALF(SZ/2)) u_merge (
          .lData(g_lvl[l-1].dat[2*g]),
          .lCnt (g_lvl[l-1].cnt[2*g]),
          .rData(g_lvl[l-1].dat[2*g+1]),
          .rCnt (g_lvl[l-1].cnt[2*g+1]),
          .mData(dat[g]),
          .mCnt (cnt[g])
        );
      end
    end
  end

  assign gPos   = g_lvl[LEVELS].dat[0];
  assign padCnt = g_lvl[LEVELS].cnt[0];
endmodule

// File: rtl/bitpart_datapath.sv
module bitpart_datapath
  import bitpart_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] ctrlIn,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] treeData [2];
  logic [WIDTH-1:0] treeCtrl [2];
  logic [WIDTH-1:0] treeOut  [2];
  logic [WIDTH:0]   treeCnt  [2];
  logic [WIDTH-1:0] zeroPart;
  logic [WIDTH-1:0] onePart;
  logic [WIDTH-1:0] resultPos;
  logic [WIDTH-1:0] result;

  // tree 0: zero-control group, positions left to right
  // tree 1: one-control group, inverted control in reversed order
  for (genvar i = 0; i < WIDTH; i++) begin : g_map
    assign treeData[0][i] = dataIn[WIDTH-1-i];
    assign treeCtrl[0][i] = ctrlIn[WIDTH-1-i];
    assign treeData[1][i] = dataIn[i];
    assign treeCtrl[1][i] = ~ctrlIn[i];
    assign zeroPart[i]    = treeOut[0][i];
    assign onePart[i]     = treeOut[1][WIDTH-1-i];
    assign result[WIDTH-1-i] = resultPos[i];
  end

  for (genvar p = 0; p < 2; p++) begin : g_tree
    bitpart_gather #(.WIDTH(WIDTH)) u_gather (
      .dPos  (treeData[p]),
      .cPos  (treeCtrl[p]),
      .gPos  (treeOut[p]),
      .padCnt(treeCnt[p])
    );
  end

  assign resultPos = zeroPart | onePart;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)          dataOut <= '0;
      else if (stb.load)  dataOut <= result;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      !stb.load |=> $stable(dataOut));
  end else begin : g_comb
    assign dataOut = result;
  end

  // the zero tree pads exactly as many places as there are one-control bits
  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    treeCnt[0][$countones(ctrlIn)]);
  p_pad_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    treeCnt[1][WIDTH - $countones(ctrlIn)]);
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (zeroPart & onePart) == '0);
  p_popcount_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(result) == $countones(dataIn));
endmodule

// File: rtl/bitpart_ctrl.sv
module bitpart_ctrl
  import bitpart_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t stb,
  output logic    outValid
);
  assign stb.load = inValid;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) outValid <= 1'b0;
      else       outValid <= inValid;
    end

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);
    p_valid_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid);
  end else begin : g_comb
    assign outValid = inValid;

    p_valid_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
      outValid == inValid);
  end
endmodule

// File: rtl/bit_partition.sv
module bit_partition
  import bitpart_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] ctrlIn,
  output logic             outValid,
  output logic [WIDTH-1:0] dataOut
);
  strobe_t stb;

  if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
    $error("WIDTH must be a power of two");
  end

  bitpart_ctrl #(.OUT_REG(OUT_REG)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .stb     (stb),
    .outValid(outValid)
  );

  bitpart_datapath #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .dataIn (dataIn),
    .ctrlIn (ctrlIn),
    .dataOut(dataOut)
  );

  p_reset_r9: assert property (@(posedge clk)
    !rstN |=> (!outValid || !OUT_REG));
endmodule

// File: tb/test_bit_partition.sv
`timescale 1ns/1ps
module test_bit_partition;
  localparam int W = 64;
  localparam int NTBL = 8;

  localparam logic [W-1:0] TBL_DATA [NTBL] = '{
    64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_FFFF_0000, 64'h8000_0000_0000_0001,
    64'h0F0F_0F0F_F0F0_F0F0, 64'hA5A5_5A5A_C3C3_3C3C, 64'h1234_5678_9ABC_DEF0,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_8000_0000};
  localparam logic [W-1:0] TBL_CTRL [NTBL] = '{
    64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_0000_0000,
    64'h00FF_00FF_00FF_00FF, 64'h0123_4567_89AB_CDEF, 64'hF0F0_0000_0F0F_FFFF,
    64'h3333_CCCC_3333_CCCC, 64'h7FFF_FFFF_FFFF_FFFE};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] ctrlIn = '0;
  logic outValid;
  logic [W-1:0] dataOut;
  logic [7:0] d8 = '0;
  logic [7:0] c8 = '0;
  logic v8 = 1'b0;
  logic ov8;
  logic [7:0] q8;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bit_partition #(.WIDTH(W), .OUT_REG(1'b1)) i_bit_partition (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dataIn(dataIn),
    .ctrlIn(ctrlIn), .outValid(outValid), .dataOut(dataOut));

  bit_partition #(.WIDTH(8), .OUT_REG(1'b1)) i_bit_partition_w8 (
    .clk(clk), .rstN(rstN), .inValid(v8), .dataIn(d8),
    .ctrlIn(c8), .outValid(ov8), .dataOut(q8));

  function automatic logic [W-1:0] refModel(logic [W-1:0] d, logic [W-1:0] c);
    logic [W-1:0] r = '0;
    int idx = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < W; i++) begin
        if (c[W-1-i] == pass[0]) begin
          r[W-1-idx] = d[W-1-i];
          idx++;
        end
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request, sample result one cycle later, then verify hold
  task automatic apply(logic [W-1:0] d, logic [W-1:0] c, string req);
    logic [W-1:0] exp = refModel(d, c);
    logic [W-1:0] held;
    @(negedge clk);
    dataIn = d; ctrlIn = c; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(dataOut == exp, req, dataOut, exp);
    check(outValid == 1'b1, "R8 valid", {63'd0, outValid}, 64'd1);
    held = dataOut;
    dataIn = ~d; ctrlIn = ~c;
    @(negedge clk);
    check(outValid == 1'b0 && dataOut == held, "R8 hold", dataOut, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(dataOut == '0 && outValid == 1'b0, "R9 reset", dataOut, '0);
    @(negedge clk); rstN = 1'b1;

    for (int t = 0; t < NTBL; t++) apply(TBL_DATA[t], TBL_CTRL[t], "R1 R2 table");
    for (int t = 0; t < 150; t++) apply({$urandom, $urandom}, {$urandom, $urandom}, "R1 R2 R3 random");

    apply(64'hC0FF_EE11_2233_4455, '0, "R4 all-zero control");
    check(dataOut == 64'hC0FF_EE11_2233_4455, "R4 identity", dataOut, 64'hC0FF_EE11_2233_4455);
    apply(64'h0BAD_F00D_7777_1111, '1, "R5 all-ones control");
    check(dataOut == 64'h0BAD_F00D_7777_1111, "R5 identity", dataOut, 64'h0BAD_F00D_7777_1111);
    apply(64'hAAAA_AAAA_AAAA_AAAA, {32{2'b01}}, "R6 alternating");
    check(dataOut == 64'hFFFF_FFFF_0000_0000, "R6 even then odd", dataOut, 64'hFFFF_FFFF_0000_0000);
    apply(64'h1357_9BDF_2468_ACE0, {32{2'b10}}, "R6 alternating inverse");
    apply(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, "R1 R2 single one bit");

    // R7: 8-bit worked example
    @(negedge clk);
    d8 = 8'b1011_0011; c8 = 8'b1001_1010; v8 = 1'b1;
    @(negedge clk);
    v8 = 1'b0;
    check(q8 == 8'b0101_1101 && ov8, "R7 example", {56'd0, q8}, 64'h5D);

    // R3: popcount preserved on a dense pattern
    apply(64'hF00F_0FF0_1248_8421, 64'h6996_9669_1EE1_E11E, "R3 permutation");
    check($countones(dataOut) == $countones(64'hF00F_0FF0_1248_8421), "R3 popcount",
          dataOut, 64'hF00F_0FF0_1248_8421);

    // R9: reset reapplied clears result
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(dataOut == '0 && outValid == 1'b0, "R9 re-reset", dataOut, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule